// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Bank

This block controls a bank of general-purpose pins from a small register bus. Each pin has a direction bit. A pin set as an output drives the value held in its output latch. A pin set as an input is sensed through a two-stage synchronizer. Software can change the output latches in two ways. It can load all of them at once through a data register. It can also change only chosen pins through separate set, clear and toggle registers, where a one in the write data acts on that pin and a zero leaves it alone. Several pins can therefore change in one write without a read-modify-write sequence.

Interrupt enables work the same way. One register enables the interrupt for every pin written as one, and another disables it for every pin written as one. A single interrupt request combines all pins that are inputs, are enabled, and are sensed high. The pad drivers sit outside the block. The block supplies a per-pin output value and output enable, and it receives a per-pin input level.

Top module: `gpio_bank16`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `pin_out` is 0, every interrupt enable is off, and `irq` is 0.
- R2: Address 4 is the direction register. A bit at 1 makes that pin an output. `pin_oe` equals the direction register, and a read at address 4 returns it.
- R3: A write to address 1 sets every output latch bit that is written as 1. Bits written as 0 keep their value.
- R4: A write to address 2 clears every output latch bit that is written as 1. Bits written as 0 keep their value.
- R5: A write to address 3 inverts every output latch bit that is written as 1. Bits written as 0 keep their value.
- R6: A write to address 0 loads all sixteen output latch bits. A read at address 0 returns the latch. `pin_out` always shows the latch, whatever the direction.
- R7: A read at address 5 returns the synchronized level of each pin. A change on `pin_in` shows there after the second rising clock edge.
- R8: A write to address 6 enables the interrupt of each pin written as 1. A write to address 7 disables the interrupt of each pin written as 1. In both cases, bits written as 0 are left alone. A read at address 6 returns the enables.
- R9: `irq` is 1 exactly when at least one pin is an input, has its interrupt enabled, and is synchronized high. It follows status timing and drops at the clock edge that disables the last such pin or makes it an output.
- R10: Writes take effect at the rising edge where `bus_we` is 1. Writes to addresses 8 to 15 change nothing. Reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| pin_in | input | 16 | Sensed pad levels (asynchronous) |
| pin_out | output | 16 | Output latch values |
| pin_oe | output | 16 | Per-pin output enable (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the interrupt qualification. `irq` must stay low when a pin is high and enabled but is set as an output, and also when an input is high but not enabled. It must then react to a mask-clear or direction write within one edge. The bench first sets up a mixed direction and mask pattern through the write-one registers. It then drives `pin_in` patterns that hit each of these combinations, and it checks the synchronizer latency edge by edge before it changes the mask and the direction under an active request.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [3:0] {
    RA_DATA   = 4'd0,
    RA_SET    = 4'd1,
    RA_CLR    = 4'd2,
    RA_TGL    = 4'd3,
    RA_DIR    = 4'd4,
    RA_STATUS = 4'd5,
    RA_MSET   = 4'd6,
    RA_MCLR   = 4'd7
  } gpio_reg_e;

  function automatic logic [15:0] w1_set(input logic [15:0] cur, input logic [15:0] w);
    return cur | w;
  endfunction

  function automatic logic [15:0] w1_clr(input logic [15:0] cur, input logic [15:0] w);
    return cur & ~w;
  endfunction

  function automatic logic [15:0] w1_tgl(input logic [15:0] cur, input logic [15:0] w);
    return cur ^ w;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage[STAGES-1];
endmodule

// File: rtl/gpio_w1_reg.sv
module gpio_w1_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         do_load,
  input  logic         do_set,
  input  logic         do_clr,
  input  logic         do_tgl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  import gpio_bank_pkg::*;

  logic         any_op;
  logic [W-1:0] nxt;

  assign any_op = do_load | do_set | do_clr | do_tgl;

  always_comb begin
    nxt = q;
    if (do_load)     nxt = wdata;
    else if (do_set) nxt = w1_set(q, wdata);
    else if (do_clr) nxt = w1_clr(q, wdata);
    else if (do_tgl) nxt = w1_tgl(q, wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  p_set_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> ((q & $past(wdata)) == $past(wdata)) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
  p_clr_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> ((q & $past(wdata)) == '0) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
  p_tgl_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_tgl |=> ((q ^ $past(q)) == $past(wdata)));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_op |=> $stable(q));
  a_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_load, do_set, do_clr, do_tgl}));
endmodule

// File: rtl/gpio_irq_or.sv
module gpio_irq_or #(
  parameter int W = 16
) (
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] dir_out,
  output logic [W-1:0] pin_hit,
  output logic         irq
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_hit
      assign pin_hit[i] = lvl[i] & mask[i] & ~dir_out[i];
    end
  endgenerate

  assign irq = |pin_hit;

  always_comb begin
    p_irq_needs_input_r9: assert (!irq || ((mask & ~dir_out) != '0));
  end
endmodule

// File: rtl/gpio_bank16.sv
module gpio_bank16 #(
  parameter int NPINS = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  import gpio_bank_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [NPINS-1:0] out_q, mask_q, dir_q, lvl_sync, pin_hit;
  logic wr_data, wr_set, wr_clr, wr_tgl, wr_dir, wr_mset, wr_mclr;
  logic [1:0] since_rst;

  assign wr_data = bus_we && bus_addr == AW'(RA_DATA);
  assign wr_set  = bus_we && bus_addr == AW'(RA_SET);
  assign wr_clr  = bus_we && bus_addr == AW'(RA_CLR);
  assign wr_tgl  = bus_we && bus_addr == AW'(RA_TGL);
  assign wr_dir  = bus_we && bus_addr == AW'(RA_DIR);
  assign wr_mset = bus_we && bus_addr == AW'(RA_MSET);
  assign wr_mclr = bus_we && bus_addr == AW'(RA_MCLR);

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(lvl_sync)
  );

  gpio_w1_reg #(.W(NPINS)) u_out (
    .clk(clk), .rst_n(rst_n),
    .do_load(wr_data), .do_set(wr_set), .do_clr(wr_clr), .do_tgl(wr_tgl),
    .wdata(bus_wdata), .q(out_q)
  );

  gpio_w1_reg #(.W(NPINS)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .do_load(1'b0), .do_set(wr_mset), .do_clr(wr_mclr), .do_tgl(1'b0),
    .wdata(bus_wdata), .q(mask_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  gpio_irq_or #(.W(NPINS)) u_irq (
    .lvl(lvl_sync), .mask(mask_q), .dir_out(dir_q), .pin_hit(pin_hit), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      AW'(RA_DATA), AW'(RA_SET), AW'(RA_CLR), AW'(RA_TGL): bus_rdata = out_q;
      AW'(RA_DIR):                                         bus_rdata = dir_q;
      AW'(RA_STATUS):                                      bus_rdata = lvl_sync;
      AW'(RA_MSET), AW'(RA_MCLR):                          bus_rdata = mask_q;
      default:                                             bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> pin_out == $past(bus_wdata));
  p_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));
  p_mset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
  p_mclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask_q & $past(bus_wdata)) == '0));
  p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> lvl_sync == $past(pin_in, 2));
  p_reset_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (pin_out == '0 && pin_oe == '0 && mask_q == '0 && !irq));
endmodule

// File: tb/gpio_bank16_test.sv
module gpio_bank16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  gpio_bank16 uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NV = 13;
  localparam logic [39:0] VEC [NV] = '{
    {4'd0, 16'h1234, 4'd0, 16'h1234},  // R6 load
    {4'd1, 16'h00F0, 4'd0, 16'h12F4},  // R3 set
    {4'd2, 16'h1204, 4'd0, 16'h00F0},  // R4 clear
    {4'd3, 16'hFF0F, 4'd0, 16'hFFFF},  // R5 toggle
    {4'd3, 16'h8001, 4'd0, 16'h7FFE},  // R5 toggle edges
    {4'd1, 16'h0000, 4'd0, 16'h7FFE},  // R3 zero write no effect
    {4'd2, 16'hFFFF, 4'd0, 16'h0000},  // R4 clear all
    {4'd4, 16'h00FF, 4'd4, 16'h00FF},  // R2 direction
    {4'd6, 16'h0F0F, 4'd6, 16'h0F0F},  // R8 mask set
    {4'd6, 16'h1000, 4'd6, 16'h1F0F},  // R8 mask set keeps others
    {4'd7, 16'h0103, 4'd6, 16'h1E0C},  // R8 mask clear
    {4'd9, 16'hFFFF, 4'd0, 16'h0000},  // R10 unmapped write ignored
    {4'd9, 16'hFFFF, 4'd9, 16'h0000}   // R10 unmapped read zero
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 16'h0);
    check("R1 pin_out", pin_out, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
    rd(4'd6, v); check("R1 mask", v, 16'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][39:36], VEC[i][35:20]);
      rd(VEC[i][19:16], v);
      check("R2-R10 table", v, VEC[i][15:0]);
      if (VEC[i][19:16] == 4'd0) check("R6 pin_out", pin_out, VEC[i][15:0]);
    end
    check("R2 pin_oe", pin_oe, 16'h00FF);

    // R7 two-edge synchronizer latency
    @(negedge clk); pin_in = 16'hA55A;
    rd(4'd5, v); check("R7 before edges", v, 16'h0000);
    @(negedge clk); rd(4'd5, v); check("R7 after one edge", v, 16'h0000);
    @(negedge clk); rd(4'd5, v); check("R7 after two edges", v, 16'hA55A);

    // R9 irq qualification: inputs 15..8, masks 0x1E0C
    pin_in = 16'h0100; repeat (3) @(negedge clk);
    check("R9 unmasked input", {15'd0, irq}, 16'h0);
    pin_in = 16'h000C; repeat (3) @(negedge clk);
    check("R9 masked output pins", {15'd0, irq}, 16'h0);
    pin_in = 16'h0200; @(negedge clk);
    check("R9 one edge", {15'd0, irq}, 16'h0);
    @(negedge clk);
    check("R9 asserted", {15'd0, irq}, 16'h1);
    wr(4'd4, 16'h02FF);
    check("R9 made output", {15'd0, irq}, 16'h0);
    wr(4'd4, 16'h00FF);
    check("R9 back to input", {15'd0, irq}, 16'h1);
    wr(4'd7, 16'h0200);
    check("R9 mask cleared", {15'd0, irq}, 16'h0);
    wr(4'd6, 16'h0200);
    check("R9 mask set again", {15'd0, irq}, 16'h1);
    wr(4'd12, 16'hFFFF);
    rd(4'd4, v); check("R10 dir untouched", v, 16'h00FF);
    rd(4'd6, v); check("R10 mask untouched", v, 16'h1E0C);

    // R1 reset again clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset oe", pin_oe, 16'h0);
    check("R1 reset irq", {15'd0, irq}, 16'h0);
    finish_run();
  end
endmodule